// File: doc/BRIEF.md
# Killable Read/Write Transaction Server

This block serves single read and write transactions against a small internal store, as one participant in a transactional-memory system. A read runs two sequential steps of one clock each: a presence lookup that records whether the addressed entry has ever been written, then a value fetch that returns the stored word, or zero for an entry that has never been written. A write runs a single store step. Each kind of transaction has its own kill line. A rising edge on that line while the transaction is running abandons it. The aborted transaction raises no completion pulse and makes no change to the store.

The block serves one transaction at a time. When a read and a write are both requested in the same idle cycle, the read goes first and the write is taken once the read has finished. A 2-bit status output reports the phase. After a completion or an abort, the status holds until the start and kill lines of that transaction kind are low, and then returns to ready.

Top module: `txn_server`

## Requirements
- R1: After reset, status is 0 (ready), `rdDone` and `wrDone` are low and `rdData` is zero.
- R2: A read is accepted only when `rdStart` is high and `rdKill` is low in an idle cycle, and a write only when `wrStart` is high and `wrKill` is low. A start held while its own kill line is high leaves the status at ready and produces no done pulse.
- R3: An accepted read performs the presence check and then the fetch, one cycle each. `rdDone` rises after the third rising edge counted from the edge that accepts the read. In that same cycle `rdData` shows the last value stored at the address, or zero if the address has never been written since reset.
- R4: An accepted write stores `wrData` at `addr`, both sampled at acceptance. `wrDone` rises after the second rising edge counted from the accepting edge, and later reads of that address return the stored value.
- R5: A rising edge of `rdKill` during either read step aborts the read. No `rdDone` follows, `rdData` keeps its previous value and status becomes 3 (killed).
- R6: A rising edge of `wrKill` during the store step aborts the write. No `wrDone` follows, the store is left unchanged and status becomes 3 (killed).
- R7: A rising edge on the kill line of the other transaction kind has no effect on a running transaction.
- R8: When both starts are valid in the same idle cycle, the read is served first. The write is accepted in the first idle cycle after the read completes, provided `wrStart` is still high.
- R9: Status codes are: 0 ready, 1 in progress (during every step), 2 done, 3 killed. Done and killed hold until that kind's start and kill lines are both low. The status returns to ready on the following edge.
- R10: Each of `rdDone` and `wrDone` is a pulse of exactly one cycle, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| rdStart | input | 1 | Request to start a read |
| wrStart | input | 1 | Request to start a write |
| rdKill | input | 1 | Read abort line; a rising edge kills a running read |
| wrKill | input | 1 | Write abort line; a rising edge kills a running write |
| addr | input | AW | Entry address, sampled when a transaction is accepted |
| wrData | input | DW | Write word, sampled when a write is accepted |
| rdDone | output | 1 | One-cycle pulse at read completion |
| wrDone | output | 1 | One-cycle pulse at write completion |
| rdData | output | DW | Read result, updated only when a read completes |
| status | output | 2 | 0 ready, 1 in progress, 2 done, 3 killed |

## Verification
The assertions assume that the inputs change only between clock edges and that reset is held for at least one edge before any request. They take an abort to mean an edge on the kill line seen by the block's own one-cycle history register, so a kill line that is already high when a transaction starts is never counted as an edge. The stimulus drives every input on the falling clock edge. It raises each kill line only after the matching transaction has been accepted, and it lowers start lines once acceptance is seen. This keeps the done and killed holding states from being entered through overlapping requests of the same kind.

// File: rtl/txn_pkg.sv
package txn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CHECK,
    ST_RD_FETCH,
    ST_WR_STORE,
    ST_RD_END,
    ST_WR_END,
    ST_RD_ABORT,
    ST_WR_ABORT
  } state_e;

  typedef enum logic [1:0] {
    STAT_READY  = 2'd0,
    STAT_BUSY   = 2'd1,
    STAT_DONE   = 2'd2,
    STAT_KILLED = 2'd3
  } stat_e;

  typedef struct packed {
    logic latchRd;
    logic latchWr;
    logic checkEn;
    logic fetchEn;
    logic storeEn;
  } ctl_t;

endpackage

// File: rtl/txn_ctrl.sv
module txn_ctrl
  import txn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdStart,
  input  logic       wrStart,
  input  logic       rdKill,
  input  logic       wrKill,
  output ctl_t       ctl,
  output logic       rdDone,
  output logic       wrDone,
  output logic [1:0] status
);

  state_e state, stateNxt;
  logic rdKillQ, wrKillQ;
  logic rdKillEdge, wrKillEdge;
  logic rdOk, wrOk, rdLinesLow, wrLinesLow;

  assign rdKillEdge = rdKill && !rdKillQ;
  assign wrKillEdge = wrKill && !wrKillQ;
  assign rdOk       = rdStart && !rdKill;
  assign wrOk       = wrStart && !wrKill;
  assign rdLinesLow = !rdStart && !rdKill;
  assign wrLinesLow = !wrStart && !wrKill;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:     if (rdOk) stateNxt = ST_RD_CHECK;
                   else if (wrOk) stateNxt = ST_WR_STORE;
      ST_RD_CHECK: stateNxt = rdKillEdge ? ST_RD_ABORT : ST_RD_FETCH;
      ST_RD_FETCH: stateNxt = rdKillEdge ? ST_RD_ABORT : ST_RD_END;
      ST_WR_STORE: stateNxt = wrKillEdge ? ST_WR_ABORT : ST_WR_END;
      ST_RD_END, ST_RD_ABORT: if (rdLinesLow) stateNxt = ST_IDLE;
      ST_WR_END, ST_WR_ABORT: if (wrLinesLow) stateNxt = ST_IDLE;
      default:     stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl         = '0;
    ctl.latchRd = (state == ST_IDLE) && rdOk;
    ctl.latchWr = (state == ST_IDLE) && !rdOk && wrOk;
    ctl.checkEn = (state == ST_RD_CHECK) && !rdKillEdge;
    ctl.fetchEn = (state == ST_RD_FETCH) && !rdKillEdge;
    ctl.storeEn = (state == ST_WR_STORE) && !wrKillEdge;
  end

  always_comb begin
    unique case (state)
      ST_IDLE:                              status = STAT_READY;
      ST_RD_CHECK, ST_RD_FETCH, ST_WR_STORE: status = STAT_BUSY;
      ST_RD_END, ST_WR_END:                 status = STAT_DONE;
      default:                              status = STAT_KILLED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rdKillQ <= 1'b0;
      wrKillQ <= 1'b0;
      rdDone  <= 1'b0;
      wrDone  <= 1'b0;
    end else begin
      state   <= stateNxt;
      rdKillQ <= rdKill;
      wrKillQ <= wrKill;
      rdDone  <= ctl.fetchEn;
      wrDone  <= ctl.storeEn;
    end
  end

  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone);
  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |=> !wrDone);
  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdDone, wrDone}));
  // R5
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == STAT_KILLED) |-> !(rdDone || wrDone));
  // R2
  blocked_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == STAT_READY && rdKill && !wrOk) |=> status == STAT_READY);
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == STAT_DONE && rdStart && wrStart) |=> status == STAT_DONE);

endmodule

// File: rtl/txn_dpath.sv
module txn_dpath
  import txn_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_t          ctl,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] present;
  logic [AW-1:0] addrQ;
  logic [DW-1:0] dataQ;
  logic hitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      hitQ    <= 1'b0;
      present <= '0;
      rdData  <= '0;
    end else begin
      if (ctl.latchRd || ctl.latchWr) addrQ <= addr;
      if (ctl.latchWr) dataQ <= wrData;
      if (ctl.checkEn) hitQ <= present[addrQ];
      if (ctl.fetchEn) rdData <= hitQ ? mem[addrQ] : '0;
      if (ctl.storeEn) present[addrQ] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.storeEn) mem[addrQ] <= dataQ;
  end

  // R3
  fetch_after_check_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fetchEn |-> $past(ctl.checkEn));
  // R4
  store_after_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.storeEn |-> $past(ctl.latchWr));
  // R7
  single_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.latchRd, ctl.latchWr, ctl.checkEn, ctl.fetchEn, ctl.storeEn}));

endmodule

// File: rtl/txn_server.sv
module txn_server
  import txn_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdStart,
  input  logic          wrStart,
  input  logic          rdKill,
  input  logic          wrKill,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic          rdDone,
  output logic          wrDone,
  output logic [DW-1:0] rdData,
  output logic [1:0]    status
);

  ctl_t ctl;

  txn_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .rdStart(rdStart), .wrStart(wrStart),
    .rdKill(rdKill), .wrKill(wrKill),
    .ctl(ctl), .rdDone(rdDone), .wrDone(wrDone), .status(status)
  );

  txn_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: tb/test_txn_server.sv
`timescale 1ns/100ps
module test_txn_server;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] S_READY = 2'd0, S_BUSY = 2'd1, S_DONE = 2'd2, S_KILLED = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdStart = 0, wrStart = 0, rdKill = 0, wrKill = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic rdDone, wrDone;
  logic [DW-1:0] rdData;
  logic [1:0] status;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [DW-1:0] refMem [DEPTH];
  bit refValid [DEPTH];
  logic        expKind [$];
  logic [DW-1:0] expData [$];

  always #2.5 clk = ~clk;

  txn_server #(.AW(AW), .DW(DW)) i_txn_server (
    .clk(clk), .rstN(rstN), .rdStart(rdStart), .wrStart(wrStart),
    .rdKill(rdKill), .wrKill(wrKill), .addr(addr), .wrData(wrData),
    .rdDone(rdDone), .wrDone(wrDone), .rdData(rdData), .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !finished && (rdDone || wrDone)) begin
      check("R10 done exclusive", {31'd0, rdDone && wrDone}, 32'd0);
      if (expKind.size() == 0) begin
        check("R2/R5/R6 unexpected done", {30'd0, rdDone, wrDone}, 32'd0);
      end else begin
        logic k;
        logic [DW-1:0] d;
        k = expKind.pop_front();
        d = expData.pop_front();
        check("R8 done kind order", {31'd0, wrDone}, {31'd0, k});
        if (!k && rdDone) check("R3 read data", {24'd0, rdData}, {24'd0, d});
      end
    end
  end

  function automatic logic [DW-1:0] refRead(input logic [AW-1:0] a);
    return refValid[a] ? refMem[a] : '0;
  endfunction

  task automatic doRead(input logic [AW-1:0] a);
    @(negedge clk);
    addr = a; rdStart = 1;
    expKind.push_back(1'b0); expData.push_back(refRead(a));
    @(negedge clk);
    rdStart = 0;
    check("R9 busy in read", {30'd0, status}, {30'd0, S_BUSY});
    @(negedge clk);
    check("R3 no early done", {31'd0, rdDone}, 32'd0);
    @(negedge clk);
    check("R3 rdDone timing", {31'd0, rdDone}, 32'd1);
    check("R9 done status", {30'd0, status}, {30'd0, S_DONE});
    @(negedge clk);
    check("R10 rdDone one cycle", {31'd0, rdDone}, 32'd0);
    check("R9 back to ready", {30'd0, status}, {30'd0, S_READY});
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrStart = 1;
    expKind.push_back(1'b1); expData.push_back('0);
    @(negedge clk);
    wrStart = 0;
    check("R9 busy in write", {30'd0, status}, {30'd0, S_BUSY});
    @(negedge clk);
    check("R4 wrDone timing", {31'd0, wrDone}, 32'd1);
    refMem[a] = d; refValid[a] = 1;
    @(negedge clk);
    check("R10 wrDone one cycle", {31'd0, wrDone}, 32'd0);
    check("R9 ready after write", {30'd0, status}, {30'd0, S_READY});
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin refValid[i] = 0; refMem[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", {30'd0, status}, {30'd0, S_READY});
    check("R1 dones", {30'd0, rdDone, wrDone}, 32'd0);
    check("R1 rdData", {24'd0, rdData}, 32'd0);

    // R3 unwritten entry reads zero, then basic writes and reads
    doRead(4'd5);
    doWrite(4'd5, 8'hA7);
    doWrite(4'd15, 8'h3C);
    doRead(4'd5);
    doRead(4'd15);
    doWrite(4'd0, 8'hFF);
    doRead(4'd0);

    // R2 start blocked while its own kill is high
    @(negedge clk);
    rdKill = 1; rdStart = 1; addr = 4'd5;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 read blocked by kill", {30'd0, status}, {30'd0, S_READY});
    end
    rdKill = 0; rdStart = 0;
    wrKill = 1; wrStart = 1; wrData = 8'h11;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 write blocked by kill", {30'd0, status}, {30'd0, S_READY});
    end
    wrKill = 0; wrStart = 0;
    doRead(4'd5);

    // R5 kill during check step
    @(negedge clk);
    addr = 4'd15; rdStart = 1;
    @(negedge clk);
    rdStart = 0; rdKill = 1;
    @(negedge clk);
    check("R5 killed in check", {30'd0, status}, {30'd0, S_KILLED});
    check("R5 rdData kept", {24'd0, rdData}, 32'h00000005 == 0 ? 0 : {24'd0, refRead(4'd5)});
    @(negedge clk);
    check("R9 killed held while kill high", {30'd0, status}, {30'd0, S_KILLED});
    rdKill = 0;
    @(negedge clk);
    check("R9 ready after kill", {30'd0, status}, {30'd0, S_READY});

    // R5 kill during fetch step
    @(negedge clk);
    addr = 4'd0; rdStart = 1;
    @(negedge clk);
    rdStart = 0;
    @(negedge clk);
    rdKill = 1;
    @(negedge clk);
    check("R5 killed in fetch", {30'd0, status}, {30'd0, S_KILLED});
    rdKill = 0;
    @(negedge clk);
    check("R5 ready after fetch kill", {30'd0, status}, {30'd0, S_READY});

    // R6 write killed in store step: memory unchanged
    @(negedge clk);
    addr = 4'd15; wrData = 8'h99; wrStart = 1;
    @(negedge clk);
    wrStart = 0; wrKill = 1;
    @(negedge clk);
    check("R6 write killed", {30'd0, status}, {30'd0, S_KILLED});
    wrKill = 0;
    @(negedge clk);
    check("R6 ready after write kill", {30'd0, status}, {30'd0, S_READY});
    doRead(4'd15);

    // R7 write-kill edge during a read is ignored
    @(negedge clk);
    addr = 4'd0; rdStart = 1;
    expKind.push_back(1'b0); expData.push_back(refRead(4'd0));
    @(negedge clk);
    rdStart = 0; wrKill = 1;
    @(negedge clk);
    check("R7 read survives write kill", {30'd0, status}, {30'd0, S_BUSY});
    wrKill = 0;
    @(negedge clk);
    check("R7 read completes", {31'd0, rdDone}, 32'd1);
    @(negedge clk);

    // R7 read-kill edge during a write is ignored
    @(negedge clk);
    addr = 4'd7; wrData = 8'h42; wrStart = 1;
    expKind.push_back(1'b1); expData.push_back('0);
    @(negedge clk);
    wrStart = 0; rdKill = 1;
    @(negedge clk);
    check("R7 write completes", {31'd0, wrDone}, 32'd1);
    refMem[7] = 8'h42; refValid[7] = 1;
    rdKill = 0;
    @(negedge clk);
    doRead(4'd7);

    // R8 simultaneous starts: read first, write waits
    @(negedge clk);
    addr = 4'd5; wrData = 8'h5D; rdStart = 1; wrStart = 1;
    expKind.push_back(1'b0); expData.push_back(refRead(4'd5));
    expKind.push_back(1'b1); expData.push_back('0);
    @(negedge clk);
    rdStart = 0;
    @(negedge clk);
    @(negedge clk);
    check("R8 read served first", {31'd0, rdDone}, 32'd1);
    check("R8 write not yet done", {31'd0, wrDone}, 32'd0);
    @(negedge clk);
    check("R8 idle between", {30'd0, status}, {30'd0, S_READY});
    @(negedge clk);
    check("R8 write accepted", {30'd0, status}, {30'd0, S_BUSY});
    @(negedge clk);
    check("R8 write done", {31'd0, wrDone}, 32'd1);
    refMem[5] = 8'h5D; refValid[5] = 1;
    wrStart = 0;
    @(negedge clk);
    check("R9 ready after pair", {30'd0, status}, {30'd0, S_READY});
    doRead(4'd5);

    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", expKind.size(), 32'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule